// File: doc/BRIEF.md
# Erase-Safe Flash Command Sequencer

This block is a host-side controller placed between a user request port and a serial flash command port. The user asks for one of three operations: erase a main-array sector, erase the information row, or run a wrap burst read. The sequencer then emits the flash commands that carry out the request, one command at a time. Each command has an opcode, a data byte, an address and a start strobe. The sequencer waits for a completion strobe before it moves on.

The flash part has a volatile wrap-enable bit, and an erase fails while that bit is set. The sequencer keeps a shadow copy of what it believes that bit to hold. Before any erase it sends a volatile parameter write that clears the bit. It sends the matching write that sets the bit again either straight after the erase (eager mode) or just before the next wrap read (lazy mode). The shadow lets it skip writes that would not change the bit. After a controller reset the shadow is marked unknown, so the first erase or wrap read always writes the bit. The sequencer never relies on a device reset to clear wrap, because the non-volatile copy may reload it as 1. An erase error reported by the flash is passed back on the response port, and wrap is restored before the sequencer returns to IDLE.

States: IDLE, CLEAR_WRAP, ERASE, RESTORE_WRAP, READ, DONE. Transitions:
- IDLE→CLEAR_WRAP: an erase is accepted while wrap is believed on or unknown.
- IDLE→ERASE: an erase is accepted while wrap is known off.
- IDLE→RESTORE_WRAP: a wrap read is accepted while wrap is believed off or unknown.
- IDLE→READ: a wrap read is accepted while wrap is known on.
- CLEAR_WRAP→ERASE: the clear write completes.
- ERASE→RESTORE_WRAP: the erase completes in eager mode, or completes with an error.
- ERASE→DONE: the erase completes cleanly in lazy mode.
- RESTORE_WRAP→READ: the set write completes and the request was a read.
- RESTORE_WRAP→DONE: the set write completes and the request was an erase.
- READ→DONE: the read completes.
- DONE→IDLE: always, after one cycle.

Top module: `flash_erase_guard`

## Requirements
- R1: After reset, req_ready is 1 and cmd_start and rsp_done are 0.
- R2: An erase command is only issued after the wrap bit has been written to 0. The write uses opcode C0h with data bit 2 = 0. It is sent when wrap is believed on, and when wrap is unknown after reset.
- R3: Every wrap write carries cfg_burst_len in data bits 1:0, the wrap value in bit 2 and zeros in bits 7:3. Its address is 0.
- R4: With cfg_eager_restore = 1, a wrap write with bit 2 = 1 follows the erase before rsp_done.
- R5: With cfg_eager_restore = 0, no wrap write follows a clean erase. A write with bit 2 = 1 is sent before the next wrap read.
- R6: A wrap write that would not change the believed wrap state is skipped. No clear is sent before an erase when wrap is known off. No set is sent before a read when wrap is known on.
- R7: Each command state raises cmd_start for exactly one cycle. It advances only on a cmd_complete that arrives in a later cycle; a cmd_complete in the same cycle as cmd_start is ignored.
- R8: req_ready is high only in IDLE, so a request held valid during a sequence is not taken again until after DONE. rsp_done is a one-cycle pulse.
- R9: If cmd_erase_err is high with the erase completion, rsp_error is 1 with rsp_done. A wrap write with bit 2 = 1 is sent first, even in lazy mode.
- R10: Request encoding: req_op bit 1 = 1 selects a wrap read (opcode 0Bh). Otherwise bit 0 picks a main erase (D8h, value 0) or an information-row erase (64h, value 1). Erase and read commands carry the request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_op | input | 2 | Operation code (see R10) |
| req_addr | input | ADDR_W | Target address |
| cfg_eager_restore | input | 1 | 1: restore wrap after each erase; 0: restore before the next read |
| cfg_burst_len | input | 2 | Burst length field kept in wrap writes |
| rsp_done | output | 1 | One-cycle end-of-sequence pulse |
| rsp_error | output | 1 | Erase error flag, valid with rsp_done |
| cmd_start | output | 1 | One-cycle command strobe |
| cmd_opcode | output | 8 | Command opcode |
| cmd_data | output | 8 | Command data byte |
| cmd_addr | output | ADDR_W | Command address |
| cmd_complete | input | 1 | Command finished strobe |
| cmd_erase_err | input | 1 | Erase failed, valid with cmd_complete |

## Verification
Two events can land in the same cycle: a command's start strobe and a completion strobe. The bench provokes this by driving a spurious cmd_complete in the exact cycle that cmd_start rises. It then judges the result from the flash side. The flash model flags any new cmd_start that arrives while its latency counter is still running. The scoreboard checks that the command order and content match the expected sequence. A second overlap is a request held valid while DONE is signalled. The bench checks that exactly one sequence runs per request.

// File: rtl/efs_pkg.sv
package efs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR_WRAP,
        ST_ERASE,
        ST_RESTORE_WRAP,
        ST_READ,
        ST_DONE
    } efs_state_e;

    localparam logic [7:0] OPC_VOL_SET    = 8'hC0;
    localparam logic [7:0] OPC_ERASE_MAIN = 8'hD8;
    localparam logic [7:0] OPC_ERASE_INFO = 8'h64;
    localparam logic [7:0] OPC_WRAP_READ  = 8'h0B;
    localparam int         WRAP_BIT       = 2;
    localparam int         BURST_W        = 2;
endpackage

// File: rtl/efs_cmd_issue.sv
// Start/acknowledge tracker: one start per command state, completion honoured only afterwards.
module efs_cmd_issue (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_state,
    input  logic cmd_complete,
    output logic cmd_start,
    output logic cmd_ack
);
    logic issued_q;

    assign cmd_start = cmd_state && !issued_q;
    assign cmd_ack   = issued_q && cmd_complete;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issued_q <= 1'b0;
        end else if (cmd_ack) begin
            issued_q <= 1'b0;
        end else if (cmd_start) begin
            issued_q <= 1'b1;
        end
    end
endmodule

// File: rtl/efs_wrap_shadow.sv
// Believed state of the device's volatile wrap bit; unknown after reset.
module efs_wrap_shadow (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ack,
    input  logic set_val,
    output logic need_clear,
    output logic need_set
);
    logic known_q;
    logic wrap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            known_q <= 1'b0;
            wrap_q  <= 1'b0;
        end else if (set_ack) begin
            known_q <= 1'b1;
            wrap_q  <= set_val;
        end
    end

    assign need_clear = !known_q || wrap_q;
    assign need_set   = !known_q || !wrap_q;
endmodule

// File: rtl/flash_erase_guard.sv
module flash_erase_guard
    import efs_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              cfg_eager_restore,
    input  logic [BURST_W-1:0] cfg_burst_len,
    output logic              rsp_done,
    output logic              rsp_error,
    output logic              cmd_start,
    output logic [7:0]        cmd_opcode,
    output logic [7:0]        cmd_data,
    output logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_complete,
    input  logic              cmd_erase_err
);
    efs_state_e        state_q, state_d;
    logic              op_read_q, op_info_q, err_q;
    logic [ADDR_W-1:0] addr_q;
    logic              accept, in_cmd, cmd_ack;
    logic              set_ack, set_val;
    logic              need_clear, need_set;

    assign accept  = req_valid && (state_q == ST_IDLE);
    assign in_cmd  = (state_q == ST_CLEAR_WRAP) || (state_q == ST_ERASE) ||
                     (state_q == ST_RESTORE_WRAP) || (state_q == ST_READ);
    assign set_ack = cmd_ack && ((state_q == ST_CLEAR_WRAP) || (state_q == ST_RESTORE_WRAP));
    assign set_val = (state_q == ST_RESTORE_WRAP);

    efs_cmd_issue u_issue (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_state    (in_cmd),
        .cmd_complete (cmd_complete),
        .cmd_start    (cmd_start),
        .cmd_ack      (cmd_ack)
    );

    efs_wrap_shadow u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_ack    (set_ack),
        .set_val    (set_val),
        .need_clear (need_clear),
        .need_set   (need_set)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request latch and error capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_read_q <= 1'b0;
            op_info_q <= 1'b0;
            err_q     <= 1'b0;
            addr_q    <= '0;
        end else if (accept) begin
            op_read_q <= req_op[1];
            op_info_q <= req_op[0];
            err_q     <= 1'b0;
            addr_q    <= req_addr;
        end else if (cmd_ack && state_q == ST_ERASE && cmd_erase_err) begin
            err_q <= 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (req_op[1]) state_d = need_set   ? ST_RESTORE_WRAP : ST_READ;
                    else           state_d = need_clear ? ST_CLEAR_WRAP   : ST_ERASE;
                end
            end
            ST_CLEAR_WRAP: if (cmd_ack) state_d = ST_ERASE;
            ST_ERASE: begin
                if (cmd_ack) begin
                    state_d = (cfg_eager_restore || cmd_erase_err) ? ST_RESTORE_WRAP : ST_DONE;
                end
            end
            ST_RESTORE_WRAP: if (cmd_ack) state_d = op_read_q ? ST_READ : ST_DONE;
            ST_READ:         if (cmd_ack) state_d = ST_DONE;
            ST_DONE:         state_d = ST_IDLE;
            default:         state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        rsp_done   = (state_q == ST_DONE);
        rsp_error  = (state_q == ST_DONE) && err_q;
        cmd_opcode = 8'h00;
        cmd_data   = 8'h00;
        cmd_addr   = '0;
        unique case (state_q)
            ST_CLEAR_WRAP, ST_RESTORE_WRAP: begin
                cmd_opcode                 = OPC_VOL_SET;
                cmd_data[BURST_W-1:0]      = cfg_burst_len;
                cmd_data[WRAP_BIT]         = (state_q == ST_RESTORE_WRAP);
            end
            ST_ERASE: begin
                cmd_opcode = op_info_q ? OPC_ERASE_INFO : OPC_ERASE_MAIN;
                cmd_addr   = addr_q;
            end
            ST_READ: begin
                cmd_opcode = OPC_WRAP_READ;
                cmd_addr   = addr_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/efs_checker.sv
module efs_checker
    import efs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              cmd_start,
    input logic [7:0]        cmd_opcode,
    input logic [7:0]        cmd_data,
    input logic              cmd_complete,
    input logic [BURST_W-1:0] cfg_burst_len
);
    // Independent view of the device wrap bit, built from the command stream.
    logic pend_q, pend_val_q, trk_known_q, trk_wrap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_val_q  <= 1'b0;
            trk_known_q <= 1'b0;
            trk_wrap_q  <= 1'b0;
        end else if (cmd_start && cmd_opcode == OPC_VOL_SET) begin
            pend_q     <= 1'b1;
            pend_val_q <= cmd_data[WRAP_BIT];
        end else if (pend_q && cmd_complete) begin
            pend_q      <= 1'b0;
            trk_known_q <= 1'b1;
            trk_wrap_q  <= pend_val_q;
        end
    end

    p_erase_wrap_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && (cmd_opcode == OPC_ERASE_MAIN || cmd_opcode == OPC_ERASE_INFO))
        |-> (trk_known_q && !trk_wrap_q && !pend_q));

    p_burst_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && cmd_opcode == OPC_VOL_SET)
        |-> (cmd_data[BURST_W-1:0] == cfg_burst_len && cmd_data[7:3] == 5'd0));

    p_single_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> !cmd_start);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_ready_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!cmd_start && !rsp_done));
endmodule

bind flash_erase_guard efs_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .rsp_done      (rsp_done),
    .cmd_start     (cmd_start),
    .cmd_opcode    (cmd_opcode),
    .cmd_data      (cmd_data),
    .cmd_complete  (cmd_complete),
    .cfg_burst_len (cfg_burst_len)
);

// File: tb/flash_erase_guard_tb.sv
module flash_erase_guard_tb;
    localparam int AW = 24;

    typedef struct {
        logic [7:0]    opc;
        logic [7:0]    data;
        logic [AW-1:0] addr;
        string         tag;
    } exp_cmd_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic          cfg_eager_restore = 1'b1;
    logic [1:0]    cfg_burst_len = 2'b00;
    logic          rsp_done, rsp_error;
    logic          cmd_start;
    logic [7:0]    cmd_opcode, cmd_data;
    logic [AW-1:0] cmd_addr;
    logic          cmd_complete = 1'b0;
    logic          cmd_erase_err = 1'b0;

    int checks = 0;
    int failures = 0;
    int rsp_cnt = 0;
    int cycles = 0;
    bit finished = 1'b0;

    exp_cmd_t exp_q[$];
    bit       rsp_q[$];

    // flash model knobs
    int lat = 1;
    int lat_cnt = 0;
    bit glitch = 1'b0;
    bit inj_err = 1'b0;
    bit cur_erase = 1'b0;

    // bench model of the wrap bit
    bit tb_known = 1'b0;
    bit tb_wrap = 1'b0;

    always #10 clk = ~clk;

    flash_erase_guard #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr),
        .cfg_eager_restore(cfg_eager_restore), .cfg_burst_len(cfg_burst_len),
        .rsp_done(rsp_done), .rsp_error(rsp_error),
        .cmd_start(cmd_start), .cmd_opcode(cmd_opcode), .cmd_data(cmd_data),
        .cmd_addr(cmd_addr), .cmd_complete(cmd_complete), .cmd_erase_err(cmd_erase_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Flash model and command monitor
    always @(negedge clk) begin
        cmd_complete  = 1'b0;
        cmd_erase_err = 1'b0;
        if (rst_n && cmd_start) begin
            chk("R7 start while flash busy", 32'(lat_cnt), 32'd0);
            if (exp_q.size() == 0) begin
                chk("R6 unexpected command", {24'd0, cmd_opcode}, 32'hFF);
            end else begin
                exp_cmd_t e;
                e = exp_q.pop_front();
                chk({e.tag, " command"}, {cmd_opcode, cmd_data, 16'd0} | 32'(cmd_addr[15:0]),
                                         {e.opc, e.data, 16'd0} | 32'(e.addr[15:0]));
            end
            cur_erase = (cmd_opcode == 8'hD8 || cmd_opcode == 8'h64);
            lat_cnt   = lat;
            if (glitch) cmd_complete = 1'b1;
        end else if (lat_cnt != 0) begin
            lat_cnt--;
            if (lat_cnt == 0) begin
                cmd_complete  = 1'b1;
                cmd_erase_err = inj_err && cur_erase;
            end
        end
    end

    // Response monitor
    always @(negedge clk) begin
        if (rst_n && rsp_done) begin
            bit e;
            e = rsp_q.pop_front();
            chk("R9 rsp_error", 32'(rsp_error), 32'(e));
            chk("R6 all expected commands issued", 32'(exp_q.size()), 32'd0);
            rsp_cnt++;
        end
    end

    task automatic push_set(input bit val, input string tag);
        exp_cmd_t e;
        e.opc = 8'hC0; e.data = {5'd0, val, cfg_burst_len}; e.addr = '0; e.tag = tag;
        exp_q.push_back(e);
        tb_known = 1'b1; tb_wrap = val;
    endtask

    task automatic push_cmd(input logic [7:0] opc, input logic [AW-1:0] a, input string tag);
        exp_cmd_t e;
        e.opc = opc; e.data = 8'h00; e.addr = a; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Driver: computes expectations, holds the request until done
    task automatic run_req(input logic [1:0] op, input logic [AW-1:0] a, input bit err);
        int target;
        bit busy_ready;
        target = rsp_cnt + 1;
        inj_err = err;
        if (op[1]) begin
            if (!tb_known || !tb_wrap) push_set(1'b1, "R5 R3 set before read");
            push_cmd(8'h0B, a, "R10 read");
        end else begin
            if (!tb_known || tb_wrap) push_set(1'b0, "R2 R3 clear before erase");
            push_cmd(op[0] ? 8'h64 : 8'hD8, a, "R10 erase");
            if (cfg_eager_restore || err) push_set(1'b1, "R4 R9 restore after erase");
            else tb_wrap = 1'b0;
        end
        rsp_q.push_back(err);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a;
        @(negedge clk);
        busy_ready = 1'b0;
        while (rsp_cnt < target && !finished) begin
            if (req_ready) busy_ready = 1'b1;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk("R8 no ready while busy", 32'(busy_ready), 32'd0);
        @(negedge clk);
        chk("R8 done is one cycle", 32'(rsp_done), 32'd0);
        inj_err = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            checks++; failures++;
            $display("FAIL watchdog: actual=%0d expected<20000", cycles);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ready after reset", 32'(req_ready), 32'd1);
        chk("R1 no start in reset", 32'(cmd_start), 32'd0);
        chk("R1 no done in reset", 32'(rsp_done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", {30'd0, req_ready, cmd_start}, 32'd2);

        // R2 R4: unknown wrap, eager mode
        cfg_eager_restore = 1'b1; cfg_burst_len = 2'b01; lat = 1;
        run_req(2'b00, 24'h001000, 1'b0);
        // R6: wrap known on, read needs no set
        run_req(2'b10, 24'h000040, 1'b0);
        // R5: lazy mode, information row erase
        cfg_eager_restore = 1'b0; cfg_burst_len = 2'b10; lat = 2;
        run_req(2'b01, 24'h000000, 1'b0);
        // R6: wrap known off, erase needs no clear
        run_req(2'b00, 24'h002000, 1'b0);
        // R5 R10: read via op 11 triggers the lazy restore
        run_req(2'b11, 24'h000080, 1'b0);
        // R7: completion collides with start
        cfg_eager_restore = 1'b1; cfg_burst_len = 2'b11; lat = 3; glitch = 1'b1;
        run_req(2'b00, 24'h003000, 1'b0);
        glitch = 1'b0;
        // R9: lazy mode with erase error still restores wrap
        cfg_eager_restore = 1'b0; cfg_burst_len = 2'b00; lat = 1;
        run_req(2'b00, 24'h004000, 1'b1);
        run_req(2'b10, 24'h0000C0, 1'b0);

        repeat (4) @(negedge clk);
        chk("R6 scoreboard drained", 32'(exp_q.size() + rsp_q.size()), 32'd0);
        summary();
    end
endmodule